// File: doc/BRIEF.md
# Seconds Counter Clock with Alarm and Trimmed Prescaler

This block keeps time as a 32-bit count of seconds. It takes a slow oscillator reference as a one-cycle enable pulse (`osc_en`), which is nominally 32.768 kHz and is sampled in the system clock domain. A programmable prescaler divides that pulse stream down to one tick per second. A periodic trim can lengthen chosen seconds so that a fast crystal can be pulled back into step. Each tick advances the seconds count.

An alarm value is compared against the count as it advances. A control/status word holds two interrupt enables and two sticky event flags, one for the per-second tick and one for the alarm. Software clears a flag by writing a one to its bit.

Software reaches four 32-bit registers over a simple write strobe and address bus. Reads are combinational from the address. Two interrupt lines, one for the tick and one for the alarm, are each asserted while their flag and their enable are both set.

Top module: `rtc_core`

## Requirements
- R1: After reset the seconds count, the alarm value and the control/status word read 0, and the trim/divider word reads 0x00007FFF.
- R2: The registers sit at offset 0x0 (seconds), 0x4 (alarm), 0x8 (control/status) and 0xC (trim/divider). `bus_rdata` follows `bus_addr` in the same cycle. Any other offset, and any unused status bit, reads as zero. The trim/divider word reads back exactly as written.
- R3: With trim disabled and divider value D in bits 15:0, one tick occurs on every (D+1)th `osc_en` pulse. Cycles with `osc_en` low do not advance the prescaler. D = 32767 gives one tick per 32768 pulses.
- R4: Each tick adds one to the seconds count, which wraps from 0xFFFFFFFF to 0. The new value is readable from the cycle after the clock edge that takes the tick.
- R5: A write to offset 0x0 replaces the seconds count at that clock edge. If a tick falls in the same cycle, the written value is kept and the tick is not added.
- R6: Bits 25:16 of the trim/divider word hold a period P, and bits 31:26 hold an addition A. When A is nonzero, counting seconds from the last restart as 0, 1, 2, …, every second k with k mod (P+1) = P lasts D+1+A pulses, and the other seconds last D+1 pulses. When A is zero, trim is off.
- R7: A write to the trim/divider word restarts both the prescaler count and the trim period count. The next tick then needs a full period of pulses.
- R8: Status bit 1 is a sticky flag that is set by every tick. Status bit 0 is a sticky flag that is set by a tick which advances the count to a value equal to the alarm register.
- R9: Writing a one to status bit 0 or bit 1 clears that flag, and writing a zero leaves it unchanged. If a flag is being set in the same cycle, setting wins.
- R10: Status bit 3 enables the tick interrupt and bit 2 enables the alarm interrupt. Both are plain read/write bits. Writing zero to the whole status word turns both enables off and leaves both flags as they were.
- R11: `irq_hz` is high exactly while the tick flag and its enable are both set, and `irq_alarm` is high exactly while the alarm flag and its enable are both set. A flag can therefore be set while its interrupt stays masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_en | input | 1 | One-cycle pulse per oscillator period |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_hz | output | 1 | Per-second tick interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
The assertions take for granted that `osc_en` is a synchronous pulse and that a write changes the divider only together with a prescaler restart. The prescaler bound is checked on that basis, and the stimulus only ever changes the divider through the trim/divider register, which always restarts the count. The bench holds each write strobe high for a single cycle and keeps addresses on the four defined offsets, except for one read of an unused offset. It sweeps small divider and trim settings, so that expected tick counts follow from simple arithmetic on the pulse count.

// File: rtl/rtc_core.sv
module rtc_core #(
  parameter int DIV_W   = 16,
  parameter int PER_W   = 10,
  parameter int ADD_W   = 6,
  parameter int DIV_RST = 32767
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        osc_en,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_hz,
  output logic        irq_alarm
);
  localparam int LIM_W = DIV_W + 1;
  localparam int PER_LO = DIV_W;
  localparam int ADD_LO = DIV_W + PER_W;
  localparam logic [3:0] A_SEC = 4'h0, A_ALM = 4'h4, A_STAT = 4'h8, A_TRIM = 4'hC;

  logic [31:0]      sec, alm;
  logic [DIV_W-1:0] div;
  logic [PER_W-1:0] per, per_cnt;
  logic [ADD_W-1:0] add;
  logic [LIM_W-1:0] pre_cnt, limit;
  logic en_hz, en_al, fl_hz, fl_al;

  logic wr_sec, wr_alm, wr_stat, wr_trim;
  assign wr_sec  = bus_we && bus_addr == A_SEC;
  assign wr_alm  = bus_we && bus_addr == A_ALM;
  assign wr_stat = bus_we && bus_addr == A_STAT;
  assign wr_trim = bus_we && bus_addr == A_TRIM;

  logic trim_due, tick, sec_adv, al_hit;
  assign trim_due = (add != '0) && (per_cnt == per);
  assign limit    = {1'b0, div} + (trim_due ? LIM_W'(add) : LIM_W'(0));
  assign tick     = osc_en && (pre_cnt == limit);
  assign sec_adv  = tick && !wr_sec;
  assign al_hit   = sec_adv && (sec + 32'd1 == alm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      per_cnt <= '0;
    end else if (wr_trim) begin
      pre_cnt <= '0;
      per_cnt <= '0;
    end else if (osc_en) begin
      if (tick) begin
        pre_cnt <= '0;
        per_cnt <= (per_cnt == per) ? '0 : per_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= DIV_W'(DIV_RST);
      per <= '0;
      add <= '0;
    end else if (wr_trim) begin
      div <= bus_wdata[DIV_W-1:0];
      per <= bus_wdata[PER_LO +: PER_W];
      add <= bus_wdata[ADD_LO +: ADD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sec <= '0;
    else if (wr_sec)   sec <= bus_wdata;
    else if (sec_adv)  sec <= sec + 32'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       alm <= '0;
    else if (wr_alm)  alm <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_hz <= 1'b0;
      en_al <= 1'b0;
      fl_hz <= 1'b0;
      fl_al <= 1'b0;
    end else begin
      if (wr_stat) begin
        en_hz <= bus_wdata[3];
        en_al <= bus_wdata[2];
      end
      fl_hz <= tick   || (fl_hz && !(wr_stat && bus_wdata[1]));
      fl_al <= al_hit || (fl_al && !(wr_stat && bus_wdata[0]));
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_SEC:   bus_rdata = sec;
      A_ALM:   bus_rdata = alm;
      A_STAT:  bus_rdata = {28'd0, en_hz, en_al, fl_hz, fl_al};
      A_TRIM:  bus_rdata = {add, per, div};
      default: bus_rdata = '0;
    endcase
  end

  assign irq_hz    = fl_hz & en_hz;
  assign irq_alarm = fl_al & en_al;
endmodule

module rtc_core_chk #(
  parameter int DIV_W = 16,
  parameter int PER_W = 10,
  parameter int ADD_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [3:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      sec,
  input logic [DIV_W:0]   pre_cnt,
  input logic [PER_W-1:0] per_cnt,
  input logic [DIV_W-1:0] div,
  input logic [ADD_W-1:0] add,
  input logic             tick,
  input logic             fl_hz,
  input logic             fl_al,
  input logic             en_hz,
  input logic             en_al
);
  logic w_sec, w_stat, w_trim;
  assign w_sec  = bus_we && bus_addr == 4'h0;
  assign w_stat = bus_we && bus_addr == 4'h8;
  assign w_trim = bus_we && bus_addr == 4'hC;

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= {1'b0, div} + (DIV_W+1)'(add)); // R3
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !w_sec |=> (sec == $past(sec) || sec == $past(sec) + 32'd1)); // R4
  AST_SEC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    w_sec |=> sec == $past(bus_wdata)); // R5
  AST_TRIM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    w_trim |=> (pre_cnt == '0 && per_cnt == '0)); // R7
  AST_HZ_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_hz) |-> $past(tick)); // R8
  AST_AL_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_al) |-> $past(tick)); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!w_stat && !tick) |=> ($stable(fl_hz) && $stable(fl_al))); // R9
  AST_ZERO_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (w_stat && bus_wdata == 32'd0) |=> (!en_hz && !en_al)); // R10
endmodule

bind rtc_core rtc_core_chk #(.DIV_W(DIV_W), .PER_W(PER_W), .ADD_W(ADD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .sec(sec), .pre_cnt(pre_cnt), .per_cnt(per_cnt),
  .div(div), .add(add), .tick(tick), .fl_hz(fl_hz), .fl_al(fl_al),
  .en_hz(en_hz), .en_al(en_al)
);

// File: tb/tb_rtc_core.sv
module tb_rtc_core;
  logic clk = 1'b0, rst_n = 1'b0, osc_en = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_hz, irq_alarm;
  int total = 0, bad = 0;

  rtc_core dut (.clk(clk), .rst_n(rst_n), .osc_en(osc_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_hz(irq_hz), .irq_alarm(irq_alarm));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_en = 1'b1;
      @(negedge clk); osc_en = 1'b0;
    end
  endtask

  function automatic int exp_ticks(input int d, input int p, input int a, input int n);
    int s = 0, used = 0, len;
    forever begin
      len = d + 1 + (((a != 0) && (s % (p + 1)) == p) ? a : 0);
      if (used + len > n) return s;
      used += len; s++;
    end
  endfunction

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(4'h0, v); chk("R1 seconds", v, 0);
    rd(4'h4, v); chk("R1 alarm", v, 0);
    rd(4'h8, v); chk("R1 status", v, 0);
    rd(4'hC, v); chk("R1 trim/div", v, 32'h0000_7FFF);
    rd(4'h2, v); chk("R2 unused offset", v, 0);
    wr(4'hC, 32'hAC15_0012); rd(4'hC, v); chk("R2 trim readback", v, 32'hAC15_0012);
    wr(4'h4, 32'h1234_5678); rd(4'h4, v); chk("R2 alarm readback", v, 32'h1234_5678);
    wr(4'h4, 32'hFFFF_0000);

    // R3 R4 R8: divider sweep without trim
    for (int d = 0; d < 5; d++)
      for (int n = 0; n < 12; n++) begin
        wr(4'h8, 32'h3);
        wr(4'h0, 0);
        wr(4'hC, d);
        pulse(n);
        rd(4'h0, v); chk($sformatf("R3 d=%0d n=%0d", d, n), v, n / (d + 1));
        rd(4'h8, v); chk("R8 tick flag", v, (n >= d + 1) ? 32'h2 : 32'h0);
      end

    // R6: trim sweep
    for (int p = 0; p < 3; p++)
      for (int a = 0; a < 4; a++) begin
        wr(4'h0, 0);
        wr(4'hC, (a << 26) | (p << 16) | 1);
        pulse(20);
        rd(4'h0, v); chk($sformatf("R6 p=%0d a=%0d", p, a), v, exp_ticks(1, p, a, 20));
      end

    // R7: restart mid-second
    wr(4'h0, 0); wr(4'hC, 3); pulse(3);
    wr(4'hC, 3); pulse(3);
    rd(4'h0, v); chk("R7 no tick after restart", v, 0);
    pulse(1); rd(4'h0, v); chk("R7 tick after full period", v, 1);

    // R4 wrap
    wr(4'hC, 0); wr(4'h0, 32'hFFFF_FFFF); pulse(1);
    rd(4'h0, v); chk("R4 wrap", v, 0);

    // R5 write beats tick
    @(negedge clk); osc_en = 1'b1; bus_we = 1'b1; bus_addr = 4'h0; bus_wdata = 100;
    @(negedge clk); osc_en = 1'b0; bus_we = 1'b0;
    rd(4'h0, v); chk("R5 write wins", v, 100);

    // R8 R11 alarm
    wr(4'h8, 32'h7); wr(4'h0, 5); wr(4'h4, 7);
    pulse(1); rd(4'h8, v); chk("R8 no alarm at 6", v[0], 0);
    chk("R11 irq_alarm low", irq_alarm, 0);
    pulse(1); rd(4'h8, v); chk("R8 alarm at 7", v[0], 1);
    chk("R11 irq_alarm high", irq_alarm, 1);
    chk("R11 irq_hz masked", irq_hz, 0);
    wr(4'h8, 32'h4); rd(4'h8, v); chk("R9 zero keeps flags", v, 32'h7);
    wr(4'h8, 32'h5); rd(4'h8, v); chk("R9 clear alarm", v, 32'h6);
    chk("R11 irq_alarm cleared", irq_alarm, 0);

    // R10 R11 tick interrupt
    wr(4'h8, 32'hA); rd(4'h8, v); chk("R10 enable hz", v, 32'h8);
    pulse(1); chk("R11 irq_hz high", irq_hz, 1);
    wr(4'h8, 0); rd(4'h8, v); chk("R10 zero write", v, 32'h2);
    chk("R11 irq_hz masked", irq_hz, 0);

    // R9 set wins over clear
    @(negedge clk); osc_en = 1'b1; bus_we = 1'b1; bus_addr = 4'h8; bus_wdata = 32'h2;
    @(negedge clk); osc_en = 1'b0; bus_we = 1'b0;
    rd(4'h8, v); chk("R9 set wins", v, 32'h2);

    // R3 default divider
    wr(4'hC, 32'h7FFF); wr(4'h0, 0);
    pulse(32767); rd(4'h0, v); chk("R3 32767 pulses", v, 0);
    pulse(1); rd(4'h0, v); chk("R3 32768 pulses", v, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule